// File: doc/BRIEF.md
# Per-Word-Valid Instruction Cache Refill Controller

This block controls refills for a direct-mapped instruction cache. Each line holds `WORDS` words, and each word has its own valid bit. A fetch hits only when the line tag matches and the addressed word is valid. On a miss to word N, the block issues one burst request that starts at the missed word. The first beat returned is that word, and it goes to the fetch unit one cycle after it arrives. The remaining beats fill the line behind it.

The `mode_full` input picks the fill policy when the miss is accepted:

- **Partial mode:** the burst runs from word N to the last word of the line and never wraps. Words below N keep the valid state they had, or become invalid if the tag changed. A later fetch of one of those lower words therefore misses and starts a fresh refill from that word.
- **Full mode:** the burst covers the whole line in wrap order, so the entire line is valid afterwards.

Single-word write-through stores update only the addressed word when the tag matches. The memory-side write belongs to a write buffer outside this block. Hit, miss and refill-beat counters let a user compare the cost of the two policies.

Top module: `icache_refill_ctrl`

## Requirements
- R1: A fetch whose tag matches and whose word valid bit is set is a hit. It raises `fetch_valid` for one cycle, two cycles after the request is accepted. No memory request is made, and `hit_cnt` increments by one.
- R2: A miss to word N raises `mem_req` for one cycle, with `mem_addr` equal to the fetch address. The first returned beat is word N, and `fetch_valid` carries that beat's data in the cycle after it arrives. `miss_cnt` increments by one.
- R3: With `mode_full`=0, `mem_len` is WORDS-N and the beats fill words N to WORDS-1 in increasing order. Words below N are not filled.
- R4: With `mode_full`=1, `mem_len` is WORDS and the beats arrive in wrap order: N to WORDS-1, then 0 to N-1. Every word of the line then hits.
- R5: A fetch of a still-invalid word in a line whose tag matches is a miss and starts a new refill from that word.
- R6: A miss with a different tag clears every valid bit of the line before the first beat is written. Words of the old tag and words below N of the new tag do not hit.
- R7: `beat_cnt` increments once per accepted beat, and a refill ends after exactly `mem_len` beats. A `mem_rvalid` outside a refill is ignored.
- R8: A store whose tag matches writes its data to the addressed word and sets that word's valid bit, leaving the other words unchanged. A store with a different tag leaves the line unchanged.
- R9: `st_stall` is high while a refill is in progress, and a store is not taken while it is high.
- R10: A fetch issued while a refill is still running waits until the refill completes. It is then looked up normally.
- R11: After reset all valid bits are clear, the three counters are zero, and `fetch_valid`, `mem_req` and `st_stall` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_full | input | 1 | Fill policy: 1 fills the whole line, 0 fills from the missed word upward |
| fetch_req | input | 1 | Fetch request, held until `fetch_valid` |
| fetch_addr | input | ADDR_W | Word address of the fetch |
| fetch_valid | output | 1 | One-cycle strobe: `fetch_data` is the requested word |
| fetch_data | output | DATA_W | Fetched instruction word |
| st_req | input | 1 | Store request; takes priority over a fetch when idle |
| st_addr | input | ADDR_W | Word address of the store |
| st_data | input | DATA_W | Store data |
| st_stall | output | 1 | Store held off; controller busy |
| mem_req | output | 1 | One-cycle burst request strobe |
| mem_addr | output | ADDR_W | Burst start word address |
| mem_len | output | clog2(WORDS+1) | Number of beats requested |
| mem_rvalid | input | 1 | Burst data beat strobe |
| mem_rdata | input | DATA_W | Burst data beat |
| hit_cnt | output | CNT_W | Accepted fetches that hit |
| miss_cnt | output | CNT_W | Accepted fetches that missed |
| beat_cnt | output | CNT_W | Refill beats taken |

## Verification
The inline assertions check properties that must hold on every cycle:

- the requested burst length matches the policy and start word;
- the critical word is released exactly one cycle after its beat;
- `fetch_valid` is a single-cycle pulse;
- the remaining-beat count stays within range;
- a line clear never coincides with a valid-bit set.

The wrap order of a full fill, the retention of lower words in a partial fill, and the fact that stale words never hit can only be shown by the bench's scenarios. The same holds for the exact effect of a store on one word, the hold-off of stores and fetches during a refill, and the counter costs of each policy.

// File: rtl/icr_pkg.sv
package icr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIT  = 2'd1,
    ST_FILL = 2'd2
  } icr_state_e;
endpackage

// File: rtl/icr_tag_valid.sv
module icr_tag_valid #(
  parameter int TAG_W = 7,
  parameter int IDX_W = 3,
  parameter int WORDS = 4,
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] look_idx,
  input  logic [TAG_W-1:0] look_tag,
  input  logic [OFF_W-1:0] look_off,
  output logic             look_hit,
  output logic             look_tag_eq,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [TAG_W-1:0] clr_tag,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [OFF_W-1:0] set_off
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [LINES];
  logic [WORDS-1:0] vld_q [LINES];

  always_comb begin
    look_tag_eq = (tag_q[look_idx] == look_tag);
    look_hit    = look_tag_eq && vld_q[look_idx][look_off];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) begin
        tag_q[i] <= '0;
        vld_q[i] <= '0;
      end
    end else begin
      if (clr_en) begin
        tag_q[clr_idx] <= clr_tag;
        vld_q[clr_idx] <= '0;
      end
      if (set_en) begin
        vld_q[set_idx][set_off] <= 1'b1;
      end
    end
  end

  // The clear of a new-tag line and a word set never share a cycle (R6)
  assert_clr_set_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(clr_en && set_en));
endmodule

// File: rtl/icr_data_ram.sv
module icr_data_ram #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/icr_perf.sv
module icr_perf #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_hit,
  input  logic             inc_miss,
  input  logic             inc_beat,
  output logic [CNT_W-1:0] hit_cnt,
  output logic [CNT_W-1:0] miss_cnt,
  output logic [CNT_W-1:0] beat_cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hit_cnt  <= '0;
      miss_cnt <= '0;
      beat_cnt <= '0;
    end else begin
      if (inc_hit)  hit_cnt  <= hit_cnt + 1'b1;
      if (inc_miss) miss_cnt <= miss_cnt + 1'b1;
      if (inc_beat) beat_cnt <= beat_cnt + 1'b1;
    end
  end

  // A lookup is either a hit or a miss, never both (R1)
  assert_hit_miss_excl_R1: assert property (@(posedge clk) disable iff (rst)
    !(inc_hit && inc_miss));
endmodule

// File: rtl/icache_refill_ctrl.sv
module icache_refill_ctrl
  import icr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int LINES  = 8,
  parameter int CNT_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       mode_full,
  input  logic                       fetch_req,
  input  logic [ADDR_W-1:0]          fetch_addr,
  output logic                       fetch_valid,
  output logic [DATA_W-1:0]          fetch_data,
  input  logic                       st_req,
  input  logic [ADDR_W-1:0]          st_addr,
  input  logic [DATA_W-1:0]          st_data,
  output logic                       st_stall,
  output logic                       mem_req,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [$clog2(WORDS+1)-1:0] mem_len,
  input  logic                       mem_rvalid,
  input  logic [DATA_W-1:0]          mem_rdata,
  output logic [CNT_W-1:0]           hit_cnt,
  output logic [CNT_W-1:0]           miss_cnt,
  output logic [CNT_W-1:0]           beat_cnt
);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LEN_W  = $clog2(WORDS + 1);
  localparam int RAM_AW = IDX_W + OFF_W;

  icr_state_e state_q;

  logic [IDX_W-1:0] fl_idx;
  logic [OFF_W-1:0] fl_off;
  logic [LEN_W-1:0] fl_left;
  logic             fl_full;
  logic             crit_pend;

  // lookup address: a store wins over a fetch in the idle state
  logic [ADDR_W-1:0] lk_addr;
  logic [OFF_W-1:0]  lk_off;
  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag;
  logic              look_hit, look_tag_eq;

  always_comb begin
    lk_addr = st_req ? st_addr : fetch_addr;
    lk_off  = lk_addr[OFF_W-1:0];
    lk_idx  = lk_addr[OFF_W +: IDX_W];
    lk_tag  = lk_addr[ADDR_W-1 -: TAG_W];
  end

  logic idle, acc_st, acc_f, hit_go, miss_go, clr_en;
  logic store_we, fill_we, set_en;
  logic [IDX_W-1:0] set_idx;
  logic [OFF_W-1:0] set_off;
  logic [RAM_AW-1:0] ram_addr;
  logic [DATA_W-1:0] ram_wdata, ram_rdata;
  logic [LEN_W-1:0]  new_len;

  always_comb begin
    idle     = (state_q == ST_IDLE);
    acc_st   = idle && st_req;
    acc_f    = idle && !st_req && fetch_req && !fetch_valid;
    hit_go   = acc_f && look_hit;
    miss_go  = acc_f && !look_hit;
    clr_en   = miss_go && !look_tag_eq;
    store_we = acc_st && look_tag_eq;
    fill_we  = (state_q == ST_FILL) && mem_rvalid;
    set_en   = store_we || fill_we;
    set_idx  = fill_we ? fl_idx : lk_idx;
    set_off  = fill_we ? fl_off : lk_off;
    ram_addr = (state_q == ST_FILL) ? {fl_idx, fl_off} : {lk_idx, lk_off};
    ram_wdata = fill_we ? mem_rdata : st_data;
    new_len  = mode_full ? LEN_W'(WORDS) : (LEN_W'(WORDS) - LEN_W'(lk_off));
    st_stall = !idle;
  end

  icr_tag_valid #(
    .TAG_W(TAG_W), .IDX_W(IDX_W), .WORDS(WORDS), .OFF_W(OFF_W)
  ) u_tags (
    .clk(clk), .rst(rst),
    .look_idx(lk_idx), .look_tag(lk_tag), .look_off(lk_off),
    .look_hit(look_hit), .look_tag_eq(look_tag_eq),
    .clr_en(clr_en), .clr_idx(lk_idx), .clr_tag(lk_tag),
    .set_en(set_en), .set_idx(set_idx), .set_off(set_off)
  );

  icr_data_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
    .clk(clk), .we(set_en), .addr(ram_addr),
    .wdata(ram_wdata), .rdata(ram_rdata)
  );

  icr_perf #(.CNT_W(CNT_W)) u_perf (
    .clk(clk), .rst(rst),
    .inc_hit(hit_go), .inc_miss(miss_go), .inc_beat(fill_we),
    .hit_cnt(hit_cnt), .miss_cnt(miss_cnt), .beat_cnt(beat_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      fetch_valid <= 1'b0;
      fetch_data  <= '0;
      mem_req     <= 1'b0;
      mem_addr    <= '0;
      mem_len     <= '0;
      fl_idx      <= '0;
      fl_off      <= '0;
      fl_left     <= '0;
      fl_full     <= 1'b0;
      crit_pend   <= 1'b0;
    end else begin
      fetch_valid <= 1'b0;
      mem_req     <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (hit_go) begin
            state_q <= ST_HIT;
          end else if (miss_go) begin
            state_q   <= ST_FILL;
            mem_req   <= 1'b1;
            mem_addr  <= fetch_addr;
            mem_len   <= new_len;
            fl_left   <= new_len;
            fl_full   <= mode_full;
            fl_idx    <= lk_idx;
            fl_off    <= lk_off;
            crit_pend <= 1'b1;
          end
        end
        ST_HIT: begin
          fetch_data  <= ram_rdata;
          fetch_valid <= 1'b1;
          state_q     <= ST_IDLE;
        end
        ST_FILL: begin
          if (mem_rvalid) begin
            fl_off  <= fl_off + 1'b1;
            fl_left <= fl_left - 1'b1;
            if (crit_pend) begin
              fetch_data  <= mem_rdata;
              fetch_valid <= 1'b1;
              crit_pend   <= 1'b0;
            end
            if (fl_left == LEN_W'(1)) state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Partial burst runs from the start word to the end of the line (R3)
  assert_len_partial_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !fl_full) |-> (mem_len == LEN_W'(WORDS) - LEN_W'(mem_addr[OFF_W-1:0])));

  // Full burst covers the whole line (R4)
  assert_len_full_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && fl_full) |-> (mem_len == LEN_W'(WORDS)));

  // Critical word released in the cycle after its beat (R2)
  assert_release_after_crit_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FILL && crit_pend && mem_rvalid) |=> fetch_valid);

  // Fetch strobe lasts a single cycle (R2)
  assert_fetch_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> !fetch_valid);

  // Remaining beats stay between one and the line size during a refill (R7)
  assert_left_range_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FILL) |-> (fl_left != '0 && fl_left <= LEN_W'(WORDS)));
endmodule

// File: tb/icache_refill_ctrl_test.sv
`timescale 1ns/1ps
module icache_refill_ctrl_test;
  localparam int AW = 12, DW = 32, WORDS = 4, LINES = 8, CW = 16, LAT = 3;
  localparam int OFFB = 2, IDXB = 3, LW = $clog2(WORDS + 1);

  logic clk = 1'b0, rst = 1'b1, mode_full = 1'b0;
  logic fetch_req = 1'b0, fetch_valid;
  logic [AW-1:0] fetch_addr = '0;
  logic [DW-1:0] fetch_data;
  logic st_req = 1'b0, st_stall;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic mem_req, mem_rvalid;
  logic [AW-1:0] mem_addr;
  logic [LW-1:0] mem_len;
  logic [DW-1:0] mem_rdata;
  logic [CW-1:0] hit_cnt, miss_cnt, beat_cnt;

  always #2.5 clk = ~clk;

  icache_refill_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WORDS(WORDS), .LINES(LINES), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .mode_full(mode_full),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data),
    .st_req(st_req), .st_addr(st_addr), .st_data(st_data), .st_stall(st_stall),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .hit_cnt(hit_cnt), .miss_cnt(miss_cnt), .beat_cnt(beat_cnt)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  logic [DW-1:0] bmem [1 << AW];
  logic [DW-1:0] exp_q [$];
  int last_addr = -1, last_len = -1;

  function automatic logic [AW-1:0] mk(int tg, int ix, int of);
    return AW'((tg << (OFFB + IDXB)) | (ix << OFFB) | of);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // memory model: wrap-order burst within the aligned line
  initial begin
    for (int i = 0; i < (1 << AW); i++) bmem[i] = (i * 32'h01000193) ^ 32'h5A5A0000;
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk);
      if (mem_req) begin
        automatic int a = int'(mem_addr);
        automatic int l = int'(mem_len);
        last_addr = a;
        last_len  = l;
        repeat (LAT - 1) @(negedge clk);
        for (int k = 0; k < l; k++) begin
          mem_rvalid = 1'b1;
          mem_rdata  = bmem[(a & ~(WORDS - 1)) + (((a % WORDS) + k) % WORDS)];
          @(negedge clk);
        end
        mem_rvalid = 1'b0;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && fetch_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected fetch_valid", fetch_data, 0);
      end else begin
        automatic logic [DW-1:0] e = exp_q.pop_front();
        chk(fetch_data == e, "R1/R2 fetch data", fetch_data, e);
      end
    end
  end

  task automatic do_fetch(input logic [AW-1:0] a, output int cyc);
    @(negedge clk);
    exp_q.push_back(bmem[a]);
    fetch_req  = 1'b1;
    fetch_addr = a;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!fetch_valid && cyc < 1000);
    fetch_req = 1'b0;
    if (cyc >= 1000) chk(1'b0, "R2 fetch timeout", cyc, 0);
  endtask

  task automatic wait_idle;
    while (st_stall) @(negedge clk);
  endtask

  task automatic hit_fetch(input logic [AW-1:0] a, input string req);
    automatic int h0 = int'(hit_cnt), m0 = int'(miss_cnt), cyc;
    do_fetch(a, cyc);
    chk(int'(hit_cnt) == h0 + 1 && int'(miss_cnt) == m0, {req, " hit count"}, hit_cnt, h0 + 1);
    chk(cyc == 2, {req, " hit latency"}, cyc, 2);
  endtask

  task automatic miss_fetch(input logic [AW-1:0] a, input int len, input string req);
    automatic int m0 = int'(miss_cnt), b0 = int'(beat_cnt), cyc;
    do_fetch(a, cyc);
    chk(int'(miss_cnt) == m0 + 1, {req, " miss count"}, miss_cnt, m0 + 1);
    chk(last_addr == int'(a), {req, " burst start"}, last_addr, a);
    chk(last_len == len, {req, " burst length"}, last_len, len);
    wait_idle();
    chk(int'(beat_cnt) == b0 + len, {req, " R7 beats"}, beat_cnt, b0 + len);
  endtask

  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    while (st_stall) @(negedge clk);
    st_req = 1'b1; st_addr = a; st_data = d;
    @(negedge clk);
    st_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    automatic int cyc, h0, b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(!fetch_valid && !mem_req && !st_stall, "R11 outputs low", {fetch_valid, mem_req, st_stall}, 0);
    chk(hit_cnt == 0 && miss_cnt == 0 && beat_cnt == 0, "R11 counters zero", hit_cnt + miss_cnt + beat_cnt, 0);

    // R2/R3 partial fill from word 2
    mode_full = 1'b0;
    miss_fetch(mk(1, 0, 2), 2, "R2 R3 partial");
    hit_fetch(mk(1, 0, 3), "R1 R3 upper word");
    // R5 lower word still invalid
    miss_fetch(mk(1, 0, 0), 4, "R5 lower word");
    hit_fetch(mk(1, 0, 1), "R1 after refill");

    // R4 full fill, wrap order
    mode_full = 1'b1;
    miss_fetch(mk(3, 1, 1), 4, "R4 full");
    hit_fetch(mk(3, 1, 0), "R4 wrapped word0");
    hit_fetch(mk(3, 1, 2), "R4 word2");
    hit_fetch(mk(3, 1, 3), "R4 word3");

    // R6 tag change clears the line
    mode_full = 1'b0;
    miss_fetch(mk(5, 1, 2), 2, "R6 new tag");
    miss_fetch(mk(5, 1, 0), 4, "R6 no stale lower");
    miss_fetch(mk(3, 1, 0), 4, "R6 old tag gone");

    // R8 store hit updates one word only
    do_store(mk(3, 1, 2), 32'hC0FFEE01);
    bmem[mk(3, 1, 2)] = 32'hC0FFEE01;
    hit_fetch(mk(3, 1, 2), "R8 stored word");
    hit_fetch(mk(3, 1, 1), "R8 neighbour unchanged");
    // R8 mismatched tag: no allocation
    do_store(mk(6, 1, 3), 32'hBADD0003);
    hit_fetch(mk(3, 1, 3), "R8 line unchanged");
    bmem[mk(6, 1, 3)] = 32'hBADD0003;
    miss_fetch(mk(6, 1, 3), 1, "R8 no allocate");

    // R9/R10 stall during refill
    b0 = int'(beat_cnt);
    do_fetch(mk(2, 2, 0), cyc);
    chk(st_stall == 1'b1, "R9 stall during refill", st_stall, 1);
    h0 = int'(hit_cnt);
    do_fetch(mk(2, 2, 3), cyc);
    chk(int'(hit_cnt) == h0 + 1, "R10 held fetch hits", hit_cnt, h0 + 1);
    chk(cyc > 2, "R10 held fetch waited", cyc, 3);
    wait_idle();
    chk(int'(beat_cnt) == b0 + 4, "R7 beats full line", beat_cnt, b0 + 4);

    // R8 store into an invalid word with matching tag
    miss_fetch(mk(4, 3, 2), 2, "R3 partial line3");
    do_store(mk(4, 3, 0), 32'h12345670);
    bmem[mk(4, 3, 0)] = 32'h12345670;
    hit_fetch(mk(4, 3, 0), "R8 store sets valid");
    miss_fetch(mk(4, 3, 1), 3, "R8 other word still invalid");

    // R7 stray beat outside refill ignored
    @(negedge clk);
    b0 = int'(beat_cnt);
    mem_rvalid = 1'b1; mem_rdata = 32'hDEADBEEF;
    @(negedge clk);
    mem_rvalid = 1'b0;
    @(negedge clk);
    chk(int'(beat_cnt) == b0, "R7 stray beat counted", beat_cnt, b0);
    hit_fetch(mk(4, 3, 0), "R7 stray beat no write");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule